// File: doc/BRIEF.md
# Keypad Scan-Code to Key-ID Translator

This block sits between a PS/2 byte receiver and the control path of a stack-based calculator. The receiver delivers each scan-code byte together with a strobe that is not aligned to the calculator clock. The translator brings that strobe into the calculator clock domain and detects its rising edge. It then follows the make, break and extended-prefix bytes of the numeric keypad. For each physical key press it produces one 5-bit key identifier.

The output is the no-key code on every cycle that carries no new press. A key press shows as a single-cycle pulse of its identifier. While a key is held down, the repeated make codes from the keyboard are dropped. Only the release of that key arms it again. Three keypad-area keys take on calculator roles: Num Lock changes the sign, Delete clears the display entry and Insert clears the stack. Any other scan code maps to the no-key code.

The byte bus must hold steady from before the strobe rises until after it falls. The strobe must stay high for at least two calculator clock cycles and must then stay low for at least two cycles before the next byte.

Top module: `keypad_keyid_xlate`

## Requirements
- R1: While reset is low and on every cycle after reset without a new press, key_id is the no-key code 5'h1E.
- R2: Plain (non-prefixed) keypad digit make codes 0x70, 0x69, 0x72, 0x7A, 0x6B, 0x73, 0x74, 0x6C, 0x75, 0x7D produce the digits 5'h00 to 5'h09 in that order.
- R3: Plain keypad make codes 0x79 ('+'), 0x7B ('-'), 0x7C ('*') and 0x71 ('.') produce 5'h0C, 5'h1C, 5'h0D and 5'h0E. The extended codes E0 5A (Enter) and E0 4A ('/') produce 5'h0A and 5'h1D.
- R4: The plain code 0x77 (Num Lock) produces the sign change 5'h1A. The extended code E0 71 (Delete) produces clear-entry 5'h0B, and E0 70 (Insert) produces clear-stack 5'h1B.
- R5: A key identifier other than the no-key code is present on key_id for exactly one clock cycle. It appears on the third rising clock edge after the strobe rises.
- R6: A scan code outside the supported set produces no output other than the no-key code.
- R7: A make code that repeats the key currently held down, with no break in between, produces no output.
- R8: The break prefix 0xF0 followed by a key's code produces no output. When it matches the held key, it re-arms that key so that its next make code fires again.
- R9: The extended prefix 0xE0 applies only to the byte that follows it. The plain codes 0x5A and 0x4A produce nothing, and the plain code 0x71 stays '.' even after an extended 0x71 has been seen.
- R10: A strobe held high for many cycles counts as a single byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Calculator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ps2_byte | input | 8 | Scan-code byte from the PS/2 receiver, stable while the strobe is high |
| ps2_strobe | input | 1 | Byte-ready strobe from the receiver, asynchronous to clk |
| key_id | output | 5 | Registered key identifier; 5'h1E when idle |

## Verification
The bench targets the prefix corner cases.

- The bench sends plain 0x5A and 0x4A, and sends 0x71 with and without the extended prefix. A design that lets the extended flag linger would give Enter or '/' from the main keyboard, or would turn the next '.' into a clear.
- The bench sends a burst of repeated makes, and overlapping presses of two keys with their releases interleaved. A design without the held-key memory would emit a digit for every typematic repeat. A design that re-armed on the wrong key's break would emit nothing on the legitimate second press.
- A strobe held high for fifty cycles exposes a level-sensitive design, which would fire on every cycle.
- The monitor checks that each pulse lasts exactly one cycle.

// File: rtl/keypad_keyid_pkg.sv
// Package: shared key identifier codes and scan-code prefix bytes.
// Assumes PS/2 scan code set 2 coming from the keyboard.
package keypad_keyid_pkg;
    localparam int KEY_W = 5;
    localparam int BYTE_W = 8;
    typedef logic [KEY_W-1:0] key_id_t;
    typedef logic [BYTE_W-1:0] scan_t;

    localparam key_id_t KID_ENTER = 5'h0A;
    localparam key_id_t KID_CLX   = 5'h0B;
    localparam key_id_t KID_PLUS  = 5'h0C;
    localparam key_id_t KID_TIMES = 5'h0D;
    localparam key_id_t KID_POINT = 5'h0E;
    localparam key_id_t KID_CHS   = 5'h1A;
    localparam key_id_t KID_CLR   = 5'h1B;
    localparam key_id_t KID_MINUS = 5'h1C;
    localparam key_id_t KID_DIV   = 5'h1D;
    localparam key_id_t KID_NONE  = 5'h1E;

    localparam scan_t SC_BREAK = 8'hF0;
    localparam scan_t SC_EXT   = 8'hE0;
endpackage

// File: rtl/strobe_sync.sv
// Module: strobe_sync
// Brings an asynchronous strobe into the clk domain through a flop chain.
// Emits a one-cycle pulse on each rising edge of the strobe.
// Assumes the strobe stays high and low for at least two clk cycles each.
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_async,
    output logic strobe_rise
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    // Shift the strobe through the synchroniser chain and keep its previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain  <= '0;
            last_q <= 1'b0;
        end else begin
            chain  <= {chain[STAGES-2:0], strobe_async};
            last_q <= chain[STAGES-1];
        end
    end

    // Rising-edge detect on the synchronised strobe.
    always_comb strobe_rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/scan_decoder.sv
// Module: scan_decoder
// Pure lookup from a scan byte, qualified by the extended-prefix flag,
// to a key identifier. Flags whether the code belongs to the calculator set.
module scan_decoder
    import keypad_keyid_pkg::*;
(
    input  logic    ext,
    input  scan_t   code,
    output key_id_t id,
    output logic    valid
);
    // Translate plain or extended codes; anything else is not supported.
    always_comb begin
        id    = KID_NONE;
        valid = 1'b1;
        if (ext) begin
            unique case (code)
                8'h5A:   id = KID_ENTER;
                8'h4A:   id = KID_DIV;
                8'h71:   id = KID_CLX;
                8'h70:   id = KID_CLR;
                default: valid = 1'b0;
            endcase
        end else begin
            unique case (code)
                8'h70:   id = 5'h00;
                8'h69:   id = 5'h01;
                8'h72:   id = 5'h02;
                8'h7A:   id = 5'h03;
                8'h6B:   id = 5'h04;
                8'h73:   id = 5'h05;
                8'h74:   id = 5'h06;
                8'h6C:   id = 5'h07;
                8'h75:   id = 5'h08;
                8'h7D:   id = 5'h09;
                8'h79:   id = KID_PLUS;
                8'h7B:   id = KID_MINUS;
                8'h7C:   id = KID_TIMES;
                8'h71:   id = KID_POINT;
                8'h77:   id = KID_CHS;
                default: valid = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/press_tracker.sv
// Module: press_tracker
// Follows the prefix bytes and the held-key state. It drives the
// registered key identifier, which is a single-cycle pulse for each new press.
// Assumes byte_evt is one cycle wide and that byte_in is valid while it is high.
module press_tracker
    import keypad_keyid_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    byte_evt,
    input  scan_t   byte_in,
    input  key_id_t dec_id,
    input  logic    dec_valid,
    output logic    ext_flag,
    output key_id_t key_id
);
    logic              brk_flag;
    logic              held_vld;
    logic [BYTE_W:0]   held_code;
    logic [BYTE_W:0]   this_code;
    logic              same_as_held;

    // The extended flag is part of a key's identity.
    always_comb begin
        this_code    = {ext_flag, byte_in};
        same_as_held = held_vld && (held_code == this_code);
    end

    // Track prefixes and the held key, and emit identifiers for new presses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_flag  <= 1'b0;
            brk_flag  <= 1'b0;
            held_vld  <= 1'b0;
            held_code <= '0;
            key_id    <= KID_NONE;
        end else begin
            key_id <= KID_NONE;
            if (byte_evt) begin
                if (byte_in == SC_BREAK) begin
                    brk_flag <= 1'b1;
                end else if (byte_in == SC_EXT) begin
                    ext_flag <= 1'b1;
                end else begin
                    ext_flag <= 1'b0;
                    brk_flag <= 1'b0;
                    if (brk_flag) begin
                        if (same_as_held) held_vld <= 1'b0;
                    end else if (!same_as_held && dec_valid) begin
                        key_id    <= dec_id;
                        held_vld  <= 1'b1;
                        held_code <= this_code;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/keypad_keyid_xlate.sv
// Module: keypad_keyid_xlate (top)
// Turns PS/2 keypad scan bytes into single-cycle calculator key identifiers.
// Assumes ps2_byte stays stable from before ps2_strobe rises until after it falls.
module keypad_keyid_xlate
    import keypad_keyid_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BYTE_W-1:0]    ps2_byte,
    input  logic                 ps2_strobe,
    output logic [KEY_W-1:0]     key_id
);
    logic    byte_evt;
    logic    ext_flag;
    key_id_t dec_id;
    logic    dec_valid;

    strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_async (ps2_strobe),
        .strobe_rise  (byte_evt)
    );

    scan_decoder u_dec (
        .ext   (ext_flag),
        .code  (ps2_byte),
        .id    (dec_id),
        .valid (dec_valid)
    );

    press_tracker u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_evt  (byte_evt),
        .byte_in   (ps2_byte),
        .dec_id    (dec_id),
        .dec_valid (dec_valid),
        .ext_flag  (ext_flag),
        .key_id    (key_id)
    );
endmodule

// File: rtl/keypad_keyid_xlate_chk.sv
// Module: keypad_keyid_xlate_chk
// Temporal checks on the translator. They are attached to the top by bind.
module keypad_keyid_xlate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_evt,
    input logic [4:0] key_id
);
    // R1: the first cycle after reset is idle.
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> key_id == 5'h1E);

    // R5: an identifier lasts one cycle only.
    a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        key_id != 5'h1E |=> key_id == 5'h1E);

    // R5: an identifier always follows a detected byte.
    a_r5_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
        key_id != 5'h1E |-> $past(byte_evt));

    // R2, R3 and R4: the output stays within the command alphabet.
    a_r3_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        (key_id <= 5'h0E) || (key_id >= 5'h1A && key_id <= 5'h1E));

    // R10: a byte event is a single pulse.
    a_r10_event_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        byte_evt |=> !byte_evt);
endmodule

bind keypad_keyid_xlate keypad_keyid_xlate_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_evt (byte_evt),
    .key_id   (key_id)
);

// File: tb/test_keypad_keyid_xlate.sv
// Scoreboard bench: the driver tasks queue the expected identifiers, and a
// monitor compares every non-idle output against the queue.
module test_keypad_keyid_xlate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ps2_byte = 8'h00;
    logic       ps2_strobe = 1'b0;
    logic [4:0] key_id;

    int checks = 0;
    int failures = 0;
    logic [4:0] exp_q[$];
    string      tag_q[$];
    string      cur_tag = "R1";
    logic       prev_busy = 1'b0;
    logic       done = 1'b0;

    localparam logic [4:0] NONE = 5'h1E;

    always #5 clk = ~clk;

    keypad_keyid_xlate i_keypad_keyid_xlate (
        .clk(clk), .rst_n(rst_n), .ps2_byte(ps2_byte),
        .ps2_strobe(ps2_strobe), .key_id(key_id)
    );

    // Monitor: pops expectations, and checks the pulse width (R5).
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_busy) begin
                checks++;
                if (key_id != NONE) begin
                    failures++;
                    $display("FAIL R5: pulse longer than one cycle, actual=%h expected=%h", key_id, NONE);
                end
                prev_busy = 1'b0;
            end else if (key_id != NONE) begin
                prev_busy = 1'b1;
                checks++;
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL %s: unexpected key_id actual=%h expected=%h", cur_tag, key_id, NONE);
                end else begin
                    automatic logic [4:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    if (key_id != e) begin
                        failures++;
                        $display("FAIL %s: actual=%h expected=%h", t, key_id, e);
                    end
                end
            end
        end
    end

    task automatic send_byte(input logic [7:0] b, input int hold = 4);
        @(negedge clk);
        ps2_byte = b;
        ps2_strobe = 1'b1;
        repeat (hold) @(negedge clk);
        ps2_strobe = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic press(input logic ext, input logic [7:0] sc, input logic [4:0] e, input string t);
        cur_tag = t;
        if (e != NONE) begin
            exp_q.push_back(e);
            tag_q.push_back(t);
        end
        if (ext) send_byte(8'hE0);
        send_byte(sc);
    endtask

    task automatic release_key(input logic ext, input logic [7:0] sc, input string t);
        cur_tag = t;
        if (ext) send_byte(8'hE0);
        send_byte(8'hF0);
        send_byte(sc);
    endtask

    // Confirms that every expected identifier has appeared and nothing is left over.
    task automatic drained(input string t);
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL %s: missing outputs actual=%0d pending expected=0", t, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a run that hangs counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] dig [10] = '{8'h70, 8'h69, 8'h72, 8'h7A, 8'h6B, 8'h73, 8'h74, 8'h6C, 8'h75, 8'h7D};
        repeat (3) @(negedge clk);
        checks++;
        if (key_id != NONE) begin
            failures++;
            $display("FAIL R1: during reset actual=%h expected=%h", key_id, NONE);
        end
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if (key_id != NONE) begin
            failures++;
            $display("FAIL R1: after reset actual=%h expected=%h", key_id, NONE);
        end

        // R2: all ten digits
        for (int i = 0; i < 10; i++) begin
            press(1'b0, dig[i], 5'(i), "R2");
            release_key(1'b0, dig[i], "R8");
        end
        drained("R2");

        // R3: operators, point, Enter and divide
        press(1'b0, 8'h79, 5'h0C, "R3"); release_key(1'b0, 8'h79, "R3");
        press(1'b0, 8'h7B, 5'h1C, "R3"); release_key(1'b0, 8'h7B, "R3");
        press(1'b0, 8'h7C, 5'h0D, "R3"); release_key(1'b0, 8'h7C, "R3");
        press(1'b0, 8'h71, 5'h0E, "R3"); release_key(1'b0, 8'h71, "R3");
        press(1'b1, 8'h5A, 5'h0A, "R3"); release_key(1'b1, 8'h5A, "R3");
        press(1'b1, 8'h4A, 5'h1D, "R3"); release_key(1'b1, 8'h4A, "R3");
        drained("R3");

        // R4: remapped function keys
        press(1'b0, 8'h77, 5'h1A, "R4"); release_key(1'b0, 8'h77, "R4");
        press(1'b1, 8'h71, 5'h0B, "R4"); release_key(1'b1, 8'h71, "R4");
        press(1'b1, 8'h70, 5'h1B, "R4"); release_key(1'b1, 8'h70, "R4");
        drained("R4");

        // R6: unsupported codes produce nothing
        press(1'b0, 8'h1C, NONE, "R6"); release_key(1'b0, 8'h1C, "R6");
        press(1'b1, 8'h69, NONE, "R6"); release_key(1'b1, 8'h69, "R6");
        drained("R6");

        // R9: the prefix applies to one byte only; plain 5A and 4A give nothing
        press(1'b0, 8'h5A, NONE, "R9"); release_key(1'b0, 8'h5A, "R9");
        press(1'b0, 8'h4A, NONE, "R9"); release_key(1'b0, 8'h4A, "R9");
        press(1'b1, 8'h71, 5'h0B, "R9"); release_key(1'b1, 8'h71, "R9");
        press(1'b0, 8'h71, 5'h0E, "R9"); release_key(1'b0, 8'h71, "R9");
        drained("R9");

        // R7: typematic repeats are discarded
        press(1'b0, 8'h73, 5'h05, "R7");
        press(1'b0, 8'h73, NONE, "R7");
        press(1'b0, 8'h73, NONE, "R7");
        drained("R7");
        // R8: a release emits nothing and re-arms the key
        release_key(1'b0, 8'h73, "R8");
        drained("R8");
        press(1'b0, 8'h73, 5'h05, "R8");
        release_key(1'b0, 8'h73, "R8");
        drained("R8");

        // R7 and R8: overlapping presses of two keys
        press(1'b0, 8'h69, 5'h01, "R7");
        press(1'b0, 8'h72, 5'h02, "R7");
        release_key(1'b0, 8'h69, "R8");
        press(1'b0, 8'h72, NONE, "R7");
        release_key(1'b0, 8'h72, "R8");
        press(1'b0, 8'h69, 5'h01, "R8");
        release_key(1'b0, 8'h69, "R8");
        drained("R8");

        // R10: a long strobe yields one byte
        cur_tag = "R10";
        exp_q.push_back(5'h09); tag_q.push_back("R10");
        send_byte(8'h7D, 50);
        release_key(1'b0, 8'h7D, "R10");
        drained("R10");

        done = 1'b1;
        finish_run();
    end
endmodule